// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block takes single and burst read or write requests from an internal valid/ready port and plays them out on an external bus. The external bus shares one 16-bit path between addresses and data. Each access opens with an address phase. During that phase the address latch strobe is high and the master drives the address onto the shared path. A data phase follows: the master drives write data, or it releases the path so the addressed device can return read data. A separate address output that is not multiplexed carries the address of each beat. A direction control steers an external transceiver. Two debug outputs mark each data beat and show which requester the current address or data belongs to.

The external device may be 16 bits wide or 8 bits wide. In 8-bit mode only the upper byte lane is used, and each 16-bit halfword becomes two byte beats, the byte at the lower address first. The length of the address phase and the length of each data beat are fixed by parameters. After a read, one idle cycle lets the external driver release the bus before the master drives it again.

Top module: `mux_bus_master`

## Requirements
- R1: `req_ready` is high only while the master is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and the address phase starts in the next cycle.
- R2: The address phase lasts ALE_CYC cycles. Throughout it, `bus_ale` is 1, `bus_ad_oe` is 1 and `bus_ad_o` holds address bits [15:0], unchanged for the whole phase.
- R3: A request moves `req_len`+1 halfwords (1 to 4). Halfword k of `req_wdata` is bits [16k+15:16k]. On a 16-bit port, write beat k drives halfword k on `bus_ad_o` with `bus_ad_oe`=1 for WAIT_CYC cycles.
- R4: On an 8-bit port, each halfword k becomes byte beats 2k and 2k+1. Beat 2k carries bits [15:8] of the halfword and beat 2k+1 carries bits [7:0]. Both go on `bus_ad_o[15:8]`, and `bus_ad_o[7:0]` is 0.
- R5: `bus_addr` is the request address during the address phase. During data beat j it is the address plus 2j on a 16-bit port, and the address plus j on an 8-bit port.
- R6: In the cycle after the last write beat, `bus_ad_oe` is 0 and `req_ready` is 1.
- R7: During a read data phase `bus_ad_oe` is 0. `bus_ad_i` is sampled at the end of the last cycle of each beat. One cycle later `rsp_valid` pulses with the halfword. On an 8-bit port the halfword is {byte from the even beat, byte from the odd beat}, both taken from `bus_ad_i[15:8]`. `rsp_valid` is never high for a write.
- R8: After the last read beat there is one cycle with `bus_ad_oe`=0 and `req_ready`=0. The master is idle in the cycle after that.
- R9: `bus_bctl` is 1 while idle, during the address phase and during the read turnaround cycle. In a data phase it is 1 for a write and 0 for a read. When `cfg_buf_dis`=1 it is always 1.
- R10: With `cfg_dbg_en`=1, `dbg_dval` is 1 in the last cycle of every data beat and 0 at all other times. With `cfg_dbg_en`=0 it stays 0.
- R11: `dbg_srcid` is all ones except when `cfg_dbg_en`=1. In that case it shows the request's `req_src` in the last address-phase cycle and in every cycle where `dbg_dval` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_port16 | input | 1 | 1: 16-bit device, 0: 8-bit device (captured per request) |
| cfg_buf_dis | input | 1 | Holds the direction control high |
| cfg_dbg_en | input | 1 | Enables the debug strobe and source ID |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request taken |
| req_addr | input | ADDR_W | Byte address of the first transfer |
| req_write | input | 1 | 1 write, 0 read |
| req_len | input | 2 | Halfword count minus one |
| req_wdata | input | 64 | Write halfwords, halfword 0 lowest |
| req_src | input | SRC_W | Requester identity |
| rsp_valid | output | 1 | Read halfword valid |
| rsp_data | output | 16 | Read halfword |
| bus_ad_o | output | 16 | Shared path, outgoing value |
| bus_ad_oe | output | 1 | Shared path drive enable |
| bus_ad_i | input | 16 | Shared path, incoming value |
| bus_ale | output | 1 | Address latch strobe |
| bus_addr | output | ADDR_W | Non-multiplexed beat address |
| bus_bctl | output | 1 | Transceiver direction control |
| dbg_dval | output | 1 | Debug data-beat strobe |
| dbg_srcid | output | SRC_W | Debug source identity |

## Verification
The bench builds the block with ALE_CYC=2 and WAIT_CYC=3. With these values the address must stay stable over more than one latch cycle. Each beat also has cycles that are not its last one, so the bench can check that the strobe and the identity output stay quiet in those cycles and that read data is taken only at the end of the beat. The default address width of 26 and source width of 5 are kept. The requests mix burst lengths of one to four halfwords, both port widths, and back-to-back requests.

// File: rtl/mux_bus_master_pkg.sv
package mux_bus_master_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ALE  = 2'd1,
      ST_DATA = 2'd2,
      ST_TURN = 2'd3
   } mbm_state_e;
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
   import mux_bus_master_pkg::*;
#(
   parameter int ALE_CYC   = 1,
   parameter int WAIT_CYC  = 2,
   parameter int MAX_BEATS = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_write,
   input  logic [$clog2(MAX_BEATS)-1:0] req_len,
   input  logic                         port16_i,
   output logic                         req_ready,
   output logic                         accept,
   output mbm_state_e                   state,
   output logic [$clog2(MAX_BEATS):0]   beat,
   output logic                         beat_end,
   output logic                         ale_last,
   output logic                         wr_q,
   output logic                         p16_q
);
   localparam int LEN_W  = $clog2(MAX_BEATS);
   localparam int BEAT_W = LEN_W + 1;
   localparam int CMAX   = (ALE_CYC > WAIT_CYC) ? ALE_CYC : WAIT_CYC;
   localparam int CNT_W  = $clog2(CMAX + 1);

   logic [CNT_W-1:0]  cnt;
   logic [BEAT_W-1:0] last_beat;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign ale_last  = (state == ST_ALE)  && (cnt == CNT_W'(ALE_CYC - 1));
   assign beat_end  = (state == ST_DATA) && (cnt == CNT_W'(WAIT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         beat      <= '0;
         last_beat <= '0;
         wr_q      <= 1'b0;
         p16_q     <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state     <= ST_ALE;
                  cnt       <= '0;
                  beat      <= '0;
                  wr_q      <= req_write;
                  p16_q     <= port16_i;
                  last_beat <= port16_i ? BEAT_W'(req_len) : BEAT_W'({req_len, 1'b1});
               end
            end
            ST_ALE: begin
               if (ale_last) begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (beat_end) begin
                  cnt <= '0;
                  if (beat == last_beat) begin
                     state <= wr_q ? ST_IDLE : ST_TURN;
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TURN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbm_lane.sv
module mbm_lane
   import mux_bus_master_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int BUS_W     = 16,
   parameter int MAX_BEATS = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         accept,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [BUS_W*MAX_BEATS-1:0]   req_wdata,
   input  mbm_state_e                   state,
   input  logic [$clog2(MAX_BEATS):0]   beat,
   input  logic                         beat_end,
   input  logic                         wr_q,
   input  logic                         p16_q,
   input  logic [BUS_W-1:0]             bus_ad_i,
   output logic [BUS_W-1:0]             bus_ad_o,
   output logic                         bus_ad_oe,
   output logic [ADDR_W-1:0]            bus_addr,
   output logic                         rsp_valid,
   output logic [BUS_W-1:0]             rsp_data
);
   localparam int HALF   = BUS_W / 2;
   localparam int LEN_W  = $clog2(MAX_BEATS);
   localparam int BEAT_W = LEN_W + 1;

   logic [ADDR_W-1:0]          base_q;
   logic [BUS_W*MAX_BEATS-1:0] wdata_q;
   logic [BUS_W-1:0]           hw [MAX_BEATS];
   logic [LEN_W-1:0]           hw_idx;
   logic [BUS_W-1:0]           cur_hw;
   logic [HALF-1:0]            cur_byte;
   logic [ADDR_W-1:0]          offset;
   logic [HALF-1:0]            hi_q;

   for (genvar g = 0; g < MAX_BEATS; g++) begin : g_hw
      assign hw[g] = wdata_q[BUS_W*g +: BUS_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         base_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   assign hw_idx   = p16_q ? beat[LEN_W-1:0] : beat[BEAT_W-1:1];
   assign cur_hw   = hw[hw_idx];
   assign cur_byte = beat[0] ? cur_hw[HALF-1:0] : cur_hw[BUS_W-1:HALF];
   assign offset   = p16_q ? ADDR_W'({beat, 1'b0}) : ADDR_W'(beat);
   assign bus_addr = (state == ST_DATA) ? base_q + offset : base_q;

   always_comb begin
      bus_ad_o  = '0;
      bus_ad_oe = 1'b0;
      if (state == ST_ALE) begin
         bus_ad_o  = base_q[BUS_W-1:0];
         bus_ad_oe = 1'b1;
      end else if (state == ST_DATA && wr_q) begin
         bus_ad_o  = p16_q ? cur_hw : {cur_byte, {HALF{1'b0}}};
         bus_ad_oe = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         hi_q      <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (beat_end && !wr_q) begin
            if (p16_q) begin
               rsp_valid <= 1'b1;
               rsp_data  <= bus_ad_i;
            end else if (!beat[0]) begin
               hi_q <= bus_ad_i[BUS_W-1:HALF];
            end else begin
               rsp_valid <= 1'b1;
               rsp_data  <= {hi_q, bus_ad_i[BUS_W-1:HALF]};
            end
         end
      end
   end
endmodule

// File: rtl/mbm_strobe.sv
module mbm_strobe
   import mux_bus_master_pkg::*;
#(
   parameter int SRC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [SRC_W-1:0] req_src,
   input  logic             cfg_buf_dis,
   input  logic             cfg_dbg_en,
   input  mbm_state_e       state,
   input  logic             wr_q,
   input  logic             ale_last,
   input  logic             beat_end,
   output logic             bus_bctl,
   output logic             dbg_dval,
   output logic [SRC_W-1:0] dbg_srcid
);
   logic [SRC_W-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_q <= '1;
      else if (accept) src_q <= req_src;
   end

   assign bus_bctl  = cfg_buf_dis || (state != ST_DATA) || wr_q;
   assign dbg_dval  = cfg_dbg_en && beat_end;
   assign dbg_srcid = (cfg_dbg_en && (ale_last || beat_end)) ? src_q : '1;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
   import mux_bus_master_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int SRC_W     = 5,
   parameter int ALE_CYC   = 1,
   parameter int WAIT_CYC  = 2,
   parameter int MAX_BEATS = 4,
   parameter int BUS_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_port16,
   input  logic                          cfg_buf_dis,
   input  logic                          cfg_dbg_en,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_write,
   input  logic [$clog2(MAX_BEATS)-1:0]  req_len,
   input  logic [BUS_W*MAX_BEATS-1:0]    req_wdata,
   input  logic [SRC_W-1:0]              req_src,
   output logic                          rsp_valid,
   output logic [BUS_W-1:0]              rsp_data,
   output logic [BUS_W-1:0]              bus_ad_o,
   output logic                          bus_ad_oe,
   input  logic [BUS_W-1:0]              bus_ad_i,
   output logic                          bus_ale,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic                          bus_bctl,
   output logic                          dbg_dval,
   output logic [SRC_W-1:0]              dbg_srcid
);
   localparam int BEAT_W = $clog2(MAX_BEATS) + 1;

   if (ALE_CYC < 1)  begin : g_bad_ale  $error("ALE_CYC must be at least 1"); end
   if (WAIT_CYC < 1) begin : g_bad_wait $error("WAIT_CYC must be at least 1"); end
   if (MAX_BEATS < 2 || (MAX_BEATS & (MAX_BEATS - 1)) != 0)
      begin : g_bad_beats $error("MAX_BEATS must be a power of two, at least 2"); end
   if (BUS_W < 2 || BUS_W % 2 != 0 || ADDR_W < BUS_W)
      begin : g_bad_bus $error("BUS_W must be even and no wider than ADDR_W"); end

   mbm_state_e        st;
   logic [BEAT_W-1:0] beat;
   logic              accept, beat_end, ale_last, wr_q, p16_q;

   assign bus_ale = (st == ST_ALE);

   mbm_seq #(.ALE_CYC(ALE_CYC), .WAIT_CYC(WAIT_CYC), .MAX_BEATS(MAX_BEATS)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_len(req_len), .port16_i(cfg_port16), .req_ready(req_ready),
      .accept(accept), .state(st), .beat(beat), .beat_end(beat_end),
      .ale_last(ale_last), .wr_q(wr_q), .p16_q(p16_q)
   );

   mbm_lane #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .MAX_BEATS(MAX_BEATS)) u_lane (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
      .req_wdata(req_wdata), .state(st), .beat(beat), .beat_end(beat_end),
      .wr_q(wr_q), .p16_q(p16_q), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
      .bus_ad_oe(bus_ad_oe), .bus_addr(bus_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data)
   );

   mbm_strobe #(.SRC_W(SRC_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_src(req_src),
      .cfg_buf_dis(cfg_buf_dis), .cfg_dbg_en(cfg_dbg_en), .state(st),
      .wr_q(wr_q), .ale_last(ale_last), .beat_end(beat_end),
      .bus_bctl(bus_bctl), .dbg_dval(dbg_dval), .dbg_srcid(dbg_srcid)
   );
endmodule

// File: rtl/mux_bus_master_chk.sv
module mux_bus_master_chk
   import mux_bus_master_pkg::*;
#(
   parameter int SRC_W = 5,
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_dbg_en,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [BUS_W-1:0] bus_ad_o,
   input logic             bus_ad_oe,
   input logic             bus_ale,
   input logic             bus_bctl,
   input logic             dbg_dval,
   input logic [SRC_W-1:0] dbg_srcid,
   input mbm_state_e       st,
   input logic             beat_end,
   input logic             wr_q
);
   // R1
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_ale && !bus_ad_oe));
   // R2
   ale_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ale && $past(bus_ale)) |-> ($stable(bus_ad_o) && bus_ad_oe));
   // R6
   write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(beat_end && wr_q) && st != ST_DATA) |-> !bus_ad_oe);
   // R7
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && !wr_q) |-> !bus_ad_oe);
   // R7
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(beat_end && !wr_q));
   // R8
   turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TURN) |-> (!bus_ad_oe && !req_ready));
   // R9
   bctl_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> bus_bctl);
   // R11
   srcid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dbg_en |-> (dbg_srcid == '1 && !dbg_dval));
endmodule

bind mux_bus_master mux_bus_master_chk #(.SRC_W(SRC_W), .BUS_W(BUS_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_dbg_en(cfg_dbg_en), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
   .bus_ale(bus_ale), .bus_bctl(bus_bctl), .dbg_dval(dbg_dval),
   .dbg_srcid(dbg_srcid), .st(st), .beat_end(beat_end), .wr_q(wr_q)
);

// File: tb/test_mux_bus_master.sv
`timescale 1ns/1ps
module test_mux_bus_master;
   localparam int ALE_CYC  = 2;
   localparam int WAIT_CYC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_port16 = 1'b1, cfg_buf_dis = 1'b0, cfg_dbg_en = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_ready;
   logic [25:0] req_addr = '0;
   logic [1:0]  req_len = '0;
   logic [63:0] req_wdata = '0;
   logic [4:0]  req_src = '0;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic [15:0] bus_ad_o;
   logic        bus_ad_oe;
   logic [15:0] bus_ad_i = '0;
   logic        bus_ale;
   logic [25:0] bus_addr;
   logic        bus_bctl, dbg_dval;
   logic [4:0]  dbg_srcid;

   int checks = 0;
   int errors = 0;
   bit rsp_pend = 0;
   logic [15:0] rsp_exp = '0;

   always #4 clk = ~clk;

   mux_bus_master #(.ALE_CYC(ALE_CYC), .WAIT_CYC(WAIT_CYC)) i_mux_bus_master (.*);

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
      end
   endtask

   function automatic logic [15:0] rd_pat(input int b);
      return 16'(16'hC3A5 + b * 16'h1111);
   endfunction

   task automatic chk_rsp();
      chk("R7", "rsp_valid", 32'(rsp_valid), 32'(rsp_pend));
      if (rsp_pend) chk("R7", "rsp_data", 32'(rsp_data), 32'(rsp_exp));
      rsp_pend = 0;
   endtask

   task automatic chk_idle();
      chk("R1", "req_ready", 32'(req_ready), 1);
      chk("R6", "bus_ad_oe", 32'(bus_ad_oe), 0);
      chk("R2", "bus_ale", 32'(bus_ale), 0);
      chk("R9", "bus_bctl", 32'(bus_bctl), 1);
      chk("R10", "dbg_dval", 32'(dbg_dval), 0);
      chk("R11", "dbg_srcid", 32'(dbg_srcid), 32'h1F);
   endtask

   // Caller sits at a negedge with the master idle; returns at a negedge, idle.
   task automatic txn(input logic [25:0] a, input bit wr, input int nhw,
                      input logic [63:0] wd, input logic [4:0] sid);
      bit p16 = cfg_port16;
      int nb = p16 ? nhw : 2 * nhw;
      logic [15:0] hw, exp_o;
      chk("R1", "req_ready before request", 32'(req_ready), 1);
      req_valid = 1; req_addr = a; req_write = wr; req_len = 2'(nhw - 1);
      req_wdata = wd; req_src = sid;
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      for (int c = 0; c < ALE_CYC; c++) begin
         chk("R1", "req_ready in address phase", 32'(req_ready), 0);
         chk("R2", "bus_ale", 32'(bus_ale), 1);
         chk("R2", "bus_ad_oe", 32'(bus_ad_oe), 1);
         chk("R2", "bus_ad_o address", 32'(bus_ad_o), 32'(a[15:0]));
         chk("R5", "bus_addr address phase", 32'(bus_addr), 32'(a));
         chk("R9", "bus_bctl address phase", 32'(bus_bctl), 1);
         chk("R10", "dbg_dval address phase", 32'(dbg_dval), 0);
         chk("R11", "dbg_srcid address phase", 32'(dbg_srcid),
             (cfg_dbg_en && c == ALE_CYC - 1) ? 32'(sid) : 32'h1F);
         chk_rsp();
         @(negedge clk);
      end
      for (int b = 0; b < nb; b++) begin
         for (int w = 0; w < WAIT_CYC; w++) begin
            bit last = (w == WAIT_CYC - 1);
            if (!wr) bus_ad_i = rd_pat(b);
            hw = wd[16 * (p16 ? b : b / 2) +: 16];
            exp_o = p16 ? hw : {((b % 2) ? hw[7:0] : hw[15:8]), 8'h00};
            chk("R2", "bus_ale data phase", 32'(bus_ale), 0);
            chk("R5", "bus_addr beat", 32'(bus_addr), 32'(26'(a + (p16 ? 2 * b : b))));
            chk(wr ? "R3" : "R7", "bus_ad_oe data phase", 32'(bus_ad_oe), 32'(wr));
            if (wr) chk(p16 ? "R3" : "R4", "bus_ad_o write data", 32'(bus_ad_o), 32'(exp_o));
            chk("R9", "bus_bctl data phase", 32'(bus_bctl), 32'(cfg_buf_dis | wr));
            chk("R10", "dbg_dval", 32'(dbg_dval), 32'(cfg_dbg_en && last));
            chk("R11", "dbg_srcid data phase", 32'(dbg_srcid),
                (cfg_dbg_en && last) ? 32'(sid) : 32'h1F);
            chk_rsp();
            if (!wr && last && (p16 || (b % 2) == 1)) begin
               rsp_pend = 1;
               rsp_exp = p16 ? rd_pat(b) : {rd_pat(b - 1) ^ 16'h0000, 8'h00} | 16'(rd_pat(b) >> 8);
               if (!p16) rsp_exp = {rd_pat(b - 1)[15:8], rd_pat(b)[15:8]};
            end
            @(negedge clk);
         end
      end
      bus_ad_i = 16'hDEAD;
      if (!wr) begin
         chk("R8", "req_ready turnaround", 32'(req_ready), 0);
         chk("R8", "bus_ad_oe turnaround", 32'(bus_ad_oe), 0);
         chk("R9", "bus_bctl turnaround", 32'(bus_bctl), 1);
         chk_rsp();
         @(negedge clk);
      end
      chk_rsp();
      chk_idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R1, R9, R11)
      chk_idle();
      chk("R7", "rsp_valid after reset", 32'(rsp_valid), 0);
      // 16-bit single write, then burst of four (R3, R5, R6)
      txn(26'h0123456, 1, 1, 64'h0000_0000_0000_BEEF, 5'h03);
      txn(26'h2000010, 1, 4, 64'h4444_3333_2222_1111, 5'h11);
      // 16-bit read burst of three, back to back with a write (R7, R8)
      txn(26'h0000100, 0, 3, 64'h0, 5'h0A);
      txn(26'h0000200, 1, 2, 64'h0000_0000_A5A5_5A5A, 5'h1E);
      // 8-bit write of three halfwords and read of two (R4, R5)
      cfg_port16 = 0;
      txn(26'h0000301, 1, 3, 64'h0000_7788_5566_3344, 5'h05);
      txn(26'h0000400, 0, 2, 64'h0, 5'h06);
      // buffer control held high, debug off (R9, R10, R11)
      cfg_buf_dis = 1; cfg_dbg_en = 0;
      txn(26'h0000500, 0, 1, 64'h0, 5'h07);
      cfg_port16 = 1;
      txn(26'h0000600, 0, 4, 64'h0, 5'h08);
      txn(26'h0000700, 1, 1, 64'h0000_0000_0000_1234, 5'h09);
      cfg_buf_dis = 0; cfg_dbg_en = 1;
      txn(26'h3FFFFFE, 0, 2, 64'h0, 5'h00);
      repeat (2) @(negedge clk);
      chk_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule